// File: doc/BRIEF.md
# Camera Frame Capture Controller

This block sits between a parallel camera port and the capture datapath. Software arms a capture by setting an enable bit over a Wishbone slave port on the system clock. In the camera pixel clock domain the block then waits for the next vertical-sync frame start. It passes exactly one whole frame of pixels and then closes the gate again, so a capture never holds a partial frame.

The block also measures each frame in the pixel domain: the pixel clocks in the frame, the valid pixels in the frame, and a running count of completed frames. At each frame start the counts for the frame that just ended go into holding registers. A toggle handshake carries them into the bus domain, where software always reads the values of the last complete frame. A status bit uses the latched pixel count to tell a small sensor from a large one. The threshold lies midway between the two sensors' pixel counts.

A frame start is the pixel-clock cycle in which `cam_vsync` is sampled high after being sampled low. Registers are 32-bit words at word addresses: 0 control, 1 clocks per frame, 2 pixels per frame, 3 frames seen, 4 status.

Top module: `frame_capture_ctrl`

## Requirements
- R1: After reset every register reads 0 (control, clocks, pixels, frames, status) and `out_valid` is low.
- R2: A 0-to-1 change of control bit 0 (address 0) arms the gate. Pixels pass from the first frame start after arming, including a pixel valid in that start cycle. Pixels of the frame already running when arming occurs do not pass.
- R3: Single shot: passing stops at the next frame start, and the pixel in that start cycle does not pass. No further frame passes until bit 0 is cleared and set again. Writing 1 while the bit is already 1 does not re-arm.
- R4: A passed pixel appears on `out_valid`/`out_data` one pixel clock after it is sampled at the input, with its data unchanged, and in input order.
- R5: Address 1 reads the number of pixel clocks from one frame start up to the next, counting the start cycle. The value belongs to the last complete frame and stays steady while the following frame runs.
- R6: Address 2 reads the number of cycles with `cam_valid` high in the last complete frame, counting its start cycle.
- R7: Address 3 counts completed frames. The first frame start after reset only begins measurement and adds nothing.
- R8: Status bit 0 (address 4) reads 1 exactly when the latched pixel count exceeds (SMALL_PIX+LARGE_PIX)/2, and 0 otherwise.
- R9: Each request gets `wb_ack_o` for one cycle, in the cycle after it is presented. The control register reads back what was written. Writes to addresses 1 to 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Bus clock |
| sys_rst | input | 1 | Synchronous active-high reset, bus domain |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Word address |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| pix_clk | input | 1 | Camera pixel clock |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| cam_vsync | input | 1 | Vertical sync, rising edge starts a frame |
| cam_valid | input | 1 | Pixel valid |
| cam_data | input | DW | Pixel data |
| out_valid | output | 1 | Gated pixel valid |
| out_data | output | DW | Gated pixel data |

## Verification
The bench sets SMALL_PIX=20 and LARGE_PIX=80, which puts the detection threshold at 50. Frames of a few dozen pixels can then drive the status bit both ways, and it is seen to fall back after a large frame. It sets CNT_W=16 and DW=16, so each pixel carries a frame and index tag and the scoreboard can match passed pixels one by one. With short frames, arming in mid-frame, re-arming and redundant writes all fit into one run together with the boundary pixels in the start cycles.

// File: rtl/frame_capture_pkg.sv
package frame_capture_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE  = 2'd0,
    GATE_ARMED = 2'd1,
    GATE_RUN   = 2'd2
  } gate_state_e;

  localparam int ADR_W = 3;
  localparam logic [ADR_W-1:0] REG_CTRL   = 3'd0;
  localparam logic [ADR_W-1:0] REG_CLOCKS = 3'd1;
  localparam logic [ADR_W-1:0] REG_PIXELS = 3'd2;
  localparam logic [ADR_W-1:0] REG_FRAMES = 3'd3;
  localparam logic [ADR_W-1:0] REG_STATUS = 3'd4;
endpackage

// File: rtl/fcc_bit_sync.sv
module fcc_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/fcc_pix_core.sv
module fcc_pix_core
  import frame_capture_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 32
) (
  input  logic             pix_clk,
  input  logic             pix_rst,
  input  logic             arm_lvl,
  input  logic             cam_vsync,
  input  logic             cam_valid,
  input  logic [DW-1:0]    cam_data,
  output logic             out_valid,
  output logic [DW-1:0]    out_data,
  output logic [CNT_W-1:0] snap_clocks,
  output logic [CNT_W-1:0] snap_pixels,
  output logic [CNT_W-1:0] snap_frames,
  output logic             snap_tgl
);
  gate_state_e      state;
  logic             vs_q;
  logic             arm_q;
  logic             seen_sof;
  logic [CNT_W-1:0] clk_cnt;
  logic [CNT_W-1:0] pix_cnt;
  logic             sof;
  logic             arm_rise;
  logic             pass;

  assign sof      = cam_vsync & ~vs_q;
  assign arm_rise = arm_lvl & ~arm_q;
  assign pass     = ((state == GATE_ARMED) && sof) || ((state == GATE_RUN) && !sof);

  always_ff @(posedge pix_clk) begin
    if (pix_rst) begin
      state       <= GATE_IDLE;
      vs_q        <= 1'b0;
      arm_q       <= 1'b0;
      seen_sof    <= 1'b0;
      clk_cnt     <= '0;
      pix_cnt     <= '0;
      snap_clocks <= '0;
      snap_pixels <= '0;
      snap_frames <= '0;
      snap_tgl    <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
    end else begin
      vs_q      <= cam_vsync;
      arm_q     <= arm_lvl;
      out_valid <= cam_valid & pass;
      if (cam_valid) out_data <= cam_data;

      case (state)
        GATE_IDLE:  if (arm_rise) state <= GATE_ARMED;
        GATE_ARMED: if (sof)      state <= GATE_RUN;
        GATE_RUN:   if (sof)      state <= GATE_IDLE;
        default:                  state <= GATE_IDLE;
      endcase

      if (sof) begin
        clk_cnt  <= CNT_W'(1);
        pix_cnt  <= CNT_W'(cam_valid);
        seen_sof <= 1'b1;
        if (seen_sof) begin
          snap_clocks <= clk_cnt;
          snap_pixels <= pix_cnt;
          snap_frames <= snap_frames + CNT_W'(1);
          snap_tgl    <= ~snap_tgl;
        end
      end else begin
        clk_cnt <= clk_cnt + CNT_W'(1);
        pix_cnt <= pix_cnt + CNT_W'(cam_valid);
      end
    end
  end

  // R4
  out_follow_chk: assert property (@(posedge pix_clk) disable iff (pix_rst)
    out_valid |-> ($past(cam_valid) && out_data == $past(cam_data)));

  // R3
  no_skip_arm_chk: assert property (@(posedge pix_clk) disable iff (pix_rst)
    (state == GATE_IDLE) |=> (state != GATE_RUN));

  // R2
  gate_open_chk: assert property (@(posedge pix_clk) disable iff (pix_rst)
    ($rose(out_valid) && state == GATE_RUN) |-> ($past(state) == GATE_RUN || $past(sof)));

  // R7
  frame_step_chk: assert property (@(posedge pix_clk) disable iff (pix_rst)
    (snap_tgl != $past(snap_tgl)) |-> (snap_frames == $past(snap_frames) + CNT_W'(1)));
endmodule

// File: rtl/fcc_regs.sv
module fcc_regs
  import frame_capture_pkg::*;
#(
  parameter int          CNT_W     = 32,
  parameter int unsigned SMALL_PIX = 81920,
  parameter int unsigned LARGE_PIX = 327680
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_cyc_i,
  input  logic             wb_stb_i,
  input  logic             wb_we_i,
  input  logic [ADR_W-1:0] wb_adr_i,
  input  logic [31:0]      wb_dat_i,
  output logic [31:0]      wb_dat_o,
  output logic             wb_ack_o,
  input  logic [CNT_W-1:0] snap_clocks,
  input  logic [CNT_W-1:0] snap_pixels,
  input  logic [CNT_W-1:0] snap_frames,
  input  logic             snap_tgl_s,
  output logic             arm_en
);
  localparam int unsigned      THRESH_I = (SMALL_PIX + LARGE_PIX) / 2;
  localparam logic [CNT_W-1:0] THRESH   = CNT_W'(THRESH_I);

  logic             tgl_q;
  logic [CNT_W-1:0] clk_c;
  logic [CNT_W-1:0] pix_c;
  logic [CNT_W-1:0] frm_c;
  logic             model_big;
  logic             upd;
  logic             req;
  logic             unused_dat;

  assign upd        = snap_tgl_s ^ tgl_q;
  assign req        = wb_cyc_i & wb_stb_i & ~wb_ack_o;
  assign unused_dat = ^wb_dat_i[31:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_q     <= 1'b0;
      clk_c     <= '0;
      pix_c     <= '0;
      frm_c     <= '0;
      model_big <= 1'b0;
      arm_en    <= 1'b0;
      wb_ack_o  <= 1'b0;
      wb_dat_o  <= '0;
    end else begin
      tgl_q    <= snap_tgl_s;
      wb_ack_o <= req;
      if (upd) begin
        clk_c     <= snap_clocks;
        pix_c     <= snap_pixels;
        frm_c     <= snap_frames;
        model_big <= snap_pixels > THRESH;
      end
      if (req && wb_we_i && wb_adr_i == REG_CTRL) arm_en <= wb_dat_i[0];
      if (req) begin
        case (wb_adr_i)
          REG_CTRL:   wb_dat_o <= {31'd0, arm_en};
          REG_CLOCKS: wb_dat_o <= 32'(clk_c);
          REG_PIXELS: wb_dat_o <= 32'(pix_c);
          REG_FRAMES: wb_dat_o <= 32'(frm_c);
          REG_STATUS: wb_dat_o <= {31'd0, model_big};
          default:    wb_dat_o <= '0;
        endcase
      end
    end
  end

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);

  // R9
  ack_req_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(clk_c) && $stable(pix_c) && $stable(frm_c)));

  // R8
  model_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> (model_big == (pix_c > THRESH)));
endmodule

// File: rtl/frame_capture_ctrl.sv
module frame_capture_ctrl
  import frame_capture_pkg::*;
#(
  parameter int          DW          = 16,
  parameter int          CNT_W       = 32,
  parameter int unsigned SMALL_PIX   = 81920,
  parameter int unsigned LARGE_PIX   = 327680,
  parameter int          SYNC_STAGES = 2
) (
  input  logic          sys_clk,
  input  logic          sys_rst,
  input  logic          wb_cyc_i,
  input  logic          wb_stb_i,
  input  logic          wb_we_i,
  input  logic [2:0]    wb_adr_i,
  input  logic [31:0]   wb_dat_i,
  output logic [31:0]   wb_dat_o,
  output logic          wb_ack_o,
  input  logic          pix_clk,
  input  logic          pix_rst,
  input  logic          cam_vsync,
  input  logic          cam_valid,
  input  logic [DW-1:0] cam_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic             arm_en;
  logic             arm_pix;
  logic             snap_tgl;
  logic             snap_tgl_s;
  logic [CNT_W-1:0] snap_clocks;
  logic [CNT_W-1:0] snap_pixels;
  logic [CNT_W-1:0] snap_frames;

  fcc_bit_sync #(.STAGES(SYNC_STAGES)) u_arm_sync (
    .clk(pix_clk), .rst(pix_rst), .d(arm_en), .q(arm_pix)
  );

  fcc_bit_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk(sys_clk), .rst(sys_rst), .d(snap_tgl), .q(snap_tgl_s)
  );

  fcc_pix_core #(.DW(DW), .CNT_W(CNT_W)) u_core (
    .pix_clk(pix_clk), .pix_rst(pix_rst), .arm_lvl(arm_pix),
    .cam_vsync(cam_vsync), .cam_valid(cam_valid), .cam_data(cam_data),
    .out_valid(out_valid), .out_data(out_data),
    .snap_clocks(snap_clocks), .snap_pixels(snap_pixels),
    .snap_frames(snap_frames), .snap_tgl(snap_tgl)
  );

  fcc_regs #(.CNT_W(CNT_W), .SMALL_PIX(SMALL_PIX), .LARGE_PIX(LARGE_PIX)) u_regs (
    .clk(sys_clk), .rst(sys_rst),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o),
    .wb_ack_o(wb_ack_o),
    .snap_clocks(snap_clocks), .snap_pixels(snap_pixels),
    .snap_frames(snap_frames), .snap_tgl_s(snap_tgl_s), .arm_en(arm_en)
  );
endmodule

// File: tb/frame_capture_ctrl_bench.sv
module frame_capture_ctrl_bench;
  logic        sys_clk = 1'b0;
  logic        pix_clk = 1'b0;
  logic        sys_rst = 1'b1;
  logic        pix_rst = 1'b1;
  logic        wb_cyc_i = 1'b0;
  logic        wb_stb_i = 1'b0;
  logic        wb_we_i = 1'b0;
  logic [2:0]  wb_adr_i = '0;
  logic [31:0] wb_dat_i = '0;
  logic [31:0] wb_dat_o;
  logic        wb_ack_o;
  logic        cam_vsync = 1'b0;
  logic        cam_valid = 1'b0;
  logic [15:0] cam_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int frame_idx = -1;
  int popped = 0;
  bit go = 0;
  bit drv_done = 0;
  bit finished = 0;
  logic [15:0] exp_q[$];

  always #5 sys_clk = ~sys_clk;
  always #7 pix_clk = ~pix_clk;

  frame_capture_ctrl #(.DW(16), .CNT_W(16), .SMALL_PIX(20), .LARGE_PIX(80)) u_frame_capture_ctrl (
    .sys_clk(sys_clk), .sys_rst(sys_rst),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o),
    .wb_ack_o(wb_ack_o),
    .pix_clk(pix_clk), .pix_rst(pix_rst),
    .cam_vsync(cam_vsync), .cam_valid(cam_valid), .cam_data(cam_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wb_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge sys_clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 1; wb_adr_i = a; wb_dat_i = d;
    do @(negedge sys_clk); while (!wb_ack_o);
    wb_cyc_i = 0; wb_stb_i = 0; wb_we_i = 0;
  endtask

  task automatic wb_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge sys_clk);
    wb_cyc_i = 1; wb_stb_i = 1; wb_we_i = 0; wb_adr_i = a;
    do @(negedge sys_clk); while (!wb_ack_o);
    d = wb_dat_o;
    wb_cyc_i = 0; wb_stb_i = 0;
  endtask

  task automatic read_stats(input string tag, input int clks, input int pix,
                            input int frm, input int big);
    logic [31:0] v;
    wb_read(3'd1, v); chk({"R5 clocks ", tag}, v, 32'(clks));
    wb_read(3'd2, v); chk({"R6 pixels ", tag}, v, 32'(pix));
    wb_read(3'd3, v); chk({"R7 frames ", tag}, v, 32'(frm));
    wb_read(3'd4, v); chk({"R8 model ", tag}, v, 32'(big));
  endtask

  // Driver: frames back to back; expected passed pixels go to the queue.
  task automatic drive_frame(input int k, input int npix, input int len, input bit cap);
    int sent = 0;
    for (int c = 0; c < len; c++) begin
      @(negedge pix_clk);
      if (c == 0) frame_idx = k;
      cam_vsync = (c < 2);
      if (sent < npix && (c % 3) != 2) begin
        cam_valid = 1'b1;
        cam_data  = 16'(k * 256 + sent);
        if (cap) exp_q.push_back(cam_data);
        sent++;
      end else begin
        cam_valid = 1'b0;
      end
    end
  endtask

  initial begin
    wait (go);
    drive_frame(0, 12, 40, 0);
    drive_frame(1, 30, 80, 0);   // R2 armed mid-frame: nothing passes
    drive_frame(2, 60, 100, 1);  // R2 captured, start-cycle pixel included
    drive_frame(3, 16, 60, 0);   // R3 stops at this start
    drive_frame(4, 25, 50, 1);   // R3 re-armed by clear then set
    drive_frame(5, 10, 40, 0);
    drive_frame(6, 10, 40, 0);   // R3 redundant write of 1 does not re-arm
    drive_frame(7, 5, 20, 0);
    @(negedge pix_clk);
    cam_vsync = 0; cam_valid = 0;
    drv_done = 1;
  end

  // Monitor: R4 order and data of passed pixels
  always @(negedge pix_clk) begin
    if (go && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected pixel actual=%0h expected=none", out_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        popped++;
        chk("R4 pixel", 32'(out_data), 32'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge sys_clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (6) @(posedge pix_clk);
    @(negedge sys_clk); sys_rst = 0;
    @(negedge pix_clk); pix_rst = 0;
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      wb_read(3'(a), v);
      chk("R1 reset reg", v, 32'd0);
    end
    @(negedge pix_clk);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    go = 1;

    wait (frame_idx == 1);
    repeat (10) @(negedge sys_clk);
    wb_write(3'd0, 32'd1);
    wb_read(3'd0, v); chk("R9 ctrl readback", v, 32'd1);
    repeat (10) @(negedge sys_clk);
    read_stats("f0", 40, 12, 1, 0);

    wait (frame_idx == 2);
    repeat (20) @(negedge sys_clk);
    read_stats("f1", 80, 30, 2, 0);

    wait (frame_idx == 3);
    repeat (20) @(negedge sys_clk);
    read_stats("f2", 100, 60, 3, 1);
    wb_write(3'd0, 32'd0);
    repeat (20) @(negedge sys_clk);
    wb_write(3'd0, 32'd1);

    wait (frame_idx == 5);
    repeat (20) @(negedge sys_clk);
    wb_write(3'd2, 32'hFFFF);   // R9 write to read-only is ignored
    wb_write(3'd4, 32'd1);
    read_stats("f4 after ro writes", 50, 25, 5, 0);
    wb_write(3'd0, 32'd1);      // R3 already 1

    wait (frame_idx == 6);
    repeat (20) @(negedge sys_clk);
    read_stats("f5", 40, 10, 6, 0);

    wait (drv_done);
    repeat (10) @(negedge pix_clk);
    chk("R2 passed pixel total", 32'(popped), 32'd85);
    chk("R3 queue drained", 32'(exp_q.size()), 32'd0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule